// File: doc/BRIEF.md
# ATA Task-File Register Bank

This block is the device side of one ATA channel's register file as a host sees it over a small register bus. A command-block select and a control-block select each pick one of eight offsets. The command block holds the data word latch, the error/features pair, four two-byte-deep parameter registers (sector count and three address bytes), the device-select register and the status/command pair. The control block holds device control on writes and a side-effect-free copy of status on reads.

A device-behaviour model connects on the other side. It receives a one-cycle command strobe with the command code, and it sees the parameters already assembled into a 16-bit count and a 48-bit block address. When it finishes a command it pulses a completion input with new status and error bytes. That completion raises a pending interrupt. The interrupt reaches the `intrq` pin only while the interrupt-disable bit in device control is clear. The block stores and presents values only: it holds no media, moves no DMA traffic and models no cable timing.

Top module: `tf_regbank`

## Requirements
- R1: After reset, status reads 0x40 (only ready, bit 6, set), error reads 0x00, device select reads 0xA0, the parameter registers, features and data latch read zero, `intrq` and `cmd_valid` are low, and the interrupt-disable bit is clear.
- R2: Each write to command offsets 2 (count), 3, 4 or 5 (address low, mid, high) moves that register's current byte into its previous byte and stores the written byte as current. A read returns the current byte. `count_out` is {previous, current} of offset 2. `lba_out` bytes 5..0 are previous of offsets 5,4,3 followed by current of offsets 5,4,3.
- R3: Device select (offset 6) stores bits 6 (address mode: 1 = linear, 0 = cylinder/head/sector), 4 (1 = second drive) and 3:0 (head or address bits 27:24). It reads back with bits 7 and 5 forced to 1 and is presented on `lba_mode`, `slave_sel` and `head_out`.
- R4: A write to offset 7 while busy (status bit 7) is clear sets busy and clears DRQ (bit 3) and ERR (bit 0). It pulses `cmd_valid` for one cycle, starting the next cycle, with `cmd_code` equal to the written byte, and it clears the pending interrupt.
- R5: A write to offset 7 while busy is set is ignored: no `cmd_valid` pulse, and status and the pending interrupt stay unchanged.
- R6: A `dev_done` pulse while busy loads status with `dev_status` AND 0x6D, which clears busy and bits 4 and 1. It also loads error with `dev_error` and sets the pending interrupt. A `dev_done` pulse while busy is clear has no effect.
- R7: Device control is written at control offset 2, and its bit 1 is the interrupt-disable bit. `intrq` equals the pending interrupt while that bit is 0 and is low while it is 1. A pending interrupt survives while it is masked.
- R8: A read of command offset 7 returns status and clears the pending interrupt, unless a completion sets it in the same cycle. A read of control offset 2 returns the same status value and leaves the pending interrupt untouched. Other control offsets read 0.
- R9: Offset 1 reads the error register. A write to offset 1 goes to a separate features register, shown on `feat_out`, and does not change what offset 1 reads.
- R10: Offset 0 is a 16-bit latch. A host write stores `host_wdata`, a `dev_data_ld` pulse stores `dev_data` (the device wins when both occur in one cycle), and reads and `host_data_out` return the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs_cmd | input | 1 | Selects the command block |
| host_cs_ctl | input | 1 | Selects the control block |
| host_addr | input | 3 | Register offset within the selected block |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 16 | Write data (only offset 0 uses bits 15:8) |
| host_rdata | output | 16 | Read data, combinational, zero when not reading |
| intrq | output | 1 | Interrupt request to the host |
| dev_done | input | 1 | Device finished the current command |
| dev_status | input | 8 | Status byte reported on completion |
| dev_error | input | 8 | Error byte reported on completion |
| dev_data_ld | input | 1 | Device loads the data latch |
| dev_data | input | 16 | Word loaded by the device |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Last accepted command code |
| feat_out | output | 8 | Features register |
| count_out | output | 16 | Assembled sector count |
| lba_out | output | 48 | Assembled block address |
| head_out | output | 4 | Head / upper address nibble |
| slave_sel | output | 1 | Second drive selected |
| lba_mode | output | 1 | Linear addressing selected |
| host_data_out | output | 16 | Data latch contents |

## Verification
The assertions assume at most one of `host_wr` and `host_rd` per cycle and never both block selects at once. They also assume that `dev_done` means something only while a command is outstanding. The stimulus issues one access per cycle through tasks that set a single select, and it also fires `dev_done` while idle to exercise its rejection. A behavioural model in the bench tracks every register, the pending interrupt and the strobe, and compares all outputs each cycle through directed sequences and a stretch of random single accesses.

// File: rtl/tf_pkg.sv
package tf_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int OFS_W  = 3;

    // command-block offsets (decoded by host software, so positions are fixed)
    localparam logic [OFS_W-1:0] OFS_DATA    = 3'd0;
    localparam logic [OFS_W-1:0] OFS_ERRFEAT = 3'd1;
    localparam logic [OFS_W-1:0] OFS_FIRST_P = 3'd2;
    localparam logic [OFS_W-1:0] OFS_DEVSEL  = 3'd6;
    localparam logic [OFS_W-1:0] OFS_STATCMD = 3'd7;
    // control-block offset
    localparam logic [OFS_W-1:0] OFS_ALTCTL  = 3'd2;

    localparam int NUM_PAIRS = 4;

    // status bit positions
    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DRQ  = 3;
    localparam int ST_ERR  = 0;

    localparam logic [BYTE_W-1:0] ST_AT_RESET = 8'h40;
    localparam logic [BYTE_W-1:0] ST_DEV_MASK = 8'h6D;
    localparam logic [BYTE_W-1:0] DEVSEL_FIXED = 8'hA0;

    localparam int CTL_IRQ_OFF = 1;
    localparam int DS_LINEAR   = 6;
    localparam int DS_SECOND   = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] error;
        logic              pend;
        logic              cmd_v;
        logic [BYTE_W-1:0] cmd_code;
    } stat_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] feat;
        logic              linear;
        logic              second;
        logic [3:0]        head;
        logic              irq_off;
        logic [WORD_W-1:0] data;
    } bank_state_t;
endpackage

// File: rtl/tf_param_pair.sv
module tf_param_pair #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } pair_t;

    pair_t pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (wr_en) begin
            pr_d.prev = pr_q.cur;
            pr_d.cur  = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assign cur  = pr_q.cur;
    assign prev = pr_q.prev;

    // R2: a write pushes the older byte down
    a_r2_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (prev == $past(cur)) && (cur == $past(wdata)));
endmodule

// File: rtl/tf_status_ctrl.sv
module tf_status_ctrl
    import tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              stat_rd,
    input  logic              dev_done,
    input  logic [BYTE_W-1:0] dev_status,
    input  logic [BYTE_W-1:0] dev_error,
    input  logic              irq_off,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] error,
    output logic              intrq,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_code
);
    stat_state_t st_d, st_q;
    logic busy;
    logic cmd_take;
    logic done_take;

    assign busy      = st_q.status[ST_BSY];
    assign cmd_take  = cmd_wr && !busy;
    assign done_take = dev_done && busy;

    always_comb begin
        st_d       = st_q;
        st_d.cmd_v = 1'b0;
        if (cmd_take) begin
            st_d.status[ST_BSY] = 1'b1;
            st_d.status[ST_DRQ] = 1'b0;
            st_d.status[ST_ERR] = 1'b0;
            st_d.cmd_v          = 1'b1;
            st_d.cmd_code       = cmd_byte;
            st_d.pend           = 1'b0;
        end else if (done_take) begin
            st_d.status = dev_status & ST_DEV_MASK;
            st_d.error  = dev_error;
            st_d.pend   = 1'b1;
        end else if (stat_rd) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.status   <= ST_AT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign status    = st_q.status;
    assign error     = st_q.error;
    assign intrq     = st_q.pend && !irq_off;
    assign cmd_valid = st_q.cmd_v;
    assign cmd_code  = st_q.cmd_code;

    // R4: accepted command marks busy and strobes once
    a_r4_cmd_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !status[ST_BSY]) |=>
            status[ST_BSY] && !status[ST_DRQ] && !status[ST_ERR] && cmd_valid);
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R5: command during busy is dropped
    a_r5_busy_cmd_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && status[ST_BSY]) |=> !cmd_valid);
    // R6: completion ends busy and flags the interrupt
    a_r6_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_done && status[ST_BSY]) |=> !status[ST_BSY] && st_q.pend);
endmodule

// File: rtl/tf_read_mux.sv
module tf_read_mux
    import tf_pkg::*;
#(
    parameter int NP = NUM_PAIRS
) (
    input  logic                 cs_cmd,
    input  logic                 cs_ctl,
    input  logic                 rd,
    input  logic [OFS_W-1:0]     addr,
    input  logic [WORD_W-1:0]    data_word,
    input  logic [BYTE_W-1:0]    error,
    input  logic [BYTE_W-1:0]    status,
    input  logic [BYTE_W-1:0]    devsel,
    input  logic [NP*BYTE_W-1:0] pair_cur,
    output logic [WORD_W-1:0]    rdata
);
    localparam int PAD = WORD_W - BYTE_W;

    always_comb begin
        rdata = '0;
        if (rd && cs_cmd) begin
            if (addr == OFS_DATA) begin
                rdata = data_word;
            end else if (addr == OFS_ERRFEAT) begin
                rdata = {{PAD{1'b0}}, error};
            end else if (addr == OFS_DEVSEL) begin
                rdata = {{PAD{1'b0}}, devsel};
            end else if (addr == OFS_STATCMD) begin
                rdata = {{PAD{1'b0}}, status};
            end else begin
                for (int i = 0; i < NP; i++) begin
                    if (addr == OFS_FIRST_P + OFS_W'(i))
                        rdata = {{PAD{1'b0}}, pair_cur[i*BYTE_W +: BYTE_W]};
                end
            end
        end else if (rd && cs_ctl && addr == OFS_ALTCTL) begin
            rdata = {{PAD{1'b0}}, status};
        end
    end
endmodule

// File: rtl/tf_regbank.sv
module tf_regbank
    import tf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_cs_cmd,
    input  logic        host_cs_ctl,
    input  logic [2:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        intrq,
    input  logic        dev_done,
    input  logic [7:0]  dev_status,
    input  logic [7:0]  dev_error,
    input  logic        dev_data_ld,
    input  logic [15:0] dev_data,
    output logic        cmd_valid,
    output logic [7:0]  cmd_code,
    output logic [7:0]  feat_out,
    output logic [15:0] count_out,
    output logic [47:0] lba_out,
    output logic [3:0]  head_out,
    output logic        slave_sel,
    output logic        lba_mode,
    output logic [15:0] host_data_out
);
    localparam int NADDR = NUM_PAIRS - 1;   // address pairs after the count pair

    bank_state_t bk_d, bk_q;

    logic cmd_wr_any;
    logic ctl_wr_any;
    logic [BYTE_W-1:0] status_w;
    logic [BYTE_W-1:0] error_w;
    logic [BYTE_W-1:0] devsel_w;
    logic [NUM_PAIRS*BYTE_W-1:0] cur_w;
    logic [NUM_PAIRS*BYTE_W-1:0] prev_w;

    assign cmd_wr_any = host_cs_cmd && host_wr;
    assign ctl_wr_any = host_cs_ctl && host_wr && !host_cs_cmd;

    always_comb begin
        bk_d = bk_q;
        if (cmd_wr_any) begin
            if (host_addr == OFS_DATA)    bk_d.data = host_wdata;
            if (host_addr == OFS_ERRFEAT) bk_d.feat = host_wdata[BYTE_W-1:0];
            if (host_addr == OFS_DEVSEL) begin
                bk_d.linear = host_wdata[DS_LINEAR];
                bk_d.second = host_wdata[DS_SECOND];
                bk_d.head   = host_wdata[3:0];
            end
        end
        if (ctl_wr_any && host_addr == OFS_ALTCTL)
            bk_d.irq_off = host_wdata[CTL_IRQ_OFF];
        if (dev_data_ld)
            bk_d.data = dev_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
            logic sel_wr;
            assign sel_wr = cmd_wr_any && (host_addr == OFS_FIRST_P + OFS_W'(gi));
            tf_param_pair #(.W(BYTE_W)) u_pair (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (sel_wr),
                .wdata (host_wdata[BYTE_W-1:0]),
                .cur   (cur_w[gi*BYTE_W +: BYTE_W]),
                .prev  (prev_w[gi*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    tf_status_ctrl u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr_any && host_addr == OFS_STATCMD),
        .cmd_byte   (host_wdata[BYTE_W-1:0]),
        .stat_rd    (host_cs_cmd && host_rd && host_addr == OFS_STATCMD),
        .dev_done   (dev_done),
        .dev_status (dev_status),
        .dev_error  (dev_error),
        .irq_off    (bk_q.irq_off),
        .status     (status_w),
        .error      (error_w),
        .intrq      (intrq),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code)
    );

    assign devsel_w = DEVSEL_FIXED | {1'b0, bk_q.linear, 1'b0, bk_q.second, bk_q.head};

    tf_read_mux #(.NP(NUM_PAIRS)) u_rmux (
        .cs_cmd    (host_cs_cmd),
        .cs_ctl    (host_cs_ctl),
        .rd        (host_rd),
        .addr      (host_addr),
        .data_word (bk_q.data),
        .error     (error_w),
        .status    (status_w),
        .devsel    (devsel_w),
        .pair_cur  (cur_w),
        .rdata     (host_rdata)
    );

    assign count_out     = {prev_w[BYTE_W-1:0], cur_w[BYTE_W-1:0]};
    assign lba_out       = {prev_w[NUM_PAIRS*BYTE_W-1 -: NADDR*BYTE_W],
                            cur_w[NUM_PAIRS*BYTE_W-1 -: NADDR*BYTE_W]};
    assign feat_out      = bk_q.feat;
    assign head_out      = bk_q.head;
    assign slave_sel     = bk_q.second;
    assign lba_mode      = bk_q.linear;
    assign host_data_out = bk_q.data;

    // R7: masked channel never interrupts
    a_r7_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        bk_q.irq_off |-> !intrq);
    // R8: alternate status read leaves the request standing
    a_r8_alt_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_ctl && host_rd && !host_wr && !host_cs_cmd && intrq) |=> intrq);
    // R3: fixed bits of device select read as one
    a_r3_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_cmd && !host_cs_ctl && host_rd && host_addr == OFS_DEVSEL)
            |-> host_rdata[7] && host_rdata[5]);
    // R10: device load wins the data latch
    a_r10_dev_load: assert property (@(posedge clk) disable iff (!rst_n)
        dev_data_ld |=> host_data_out == $past(dev_data));
endmodule

// File: tb/tf_regbank_bench.sv
module tf_regbank_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        cs_cmd = 0, cs_ctl = 0, wr = 0, rd = 0;
    logic [2:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic        done = 0, dld = 0;
    logic [7:0]  dstat = 0, derr = 0;
    logic [15:0] ddata = 0;

    logic [15:0] rdata, data_out;
    logic        intrq, cmd_valid, slave_sel, lba_mode;
    logic [7:0]  cmd_code, feat_out;
    logic [15:0] count_out;
    logic [47:0] lba_out;
    logic [3:0]  head_out;

    tf_regbank u_tf_regbank (
        .clk(clk), .rst_n(rst_n),
        .host_cs_cmd(cs_cmd), .host_cs_ctl(cs_ctl), .host_addr(addr),
        .host_wr(wr), .host_rd(rd), .host_wdata(wdata), .host_rdata(rdata),
        .intrq(intrq), .dev_done(done), .dev_status(dstat), .dev_error(derr),
        .dev_data_ld(dld), .dev_data(ddata),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .feat_out(feat_out),
        .count_out(count_out), .lba_out(lba_out), .head_out(head_out),
        .slave_sel(slave_sel), .lba_mode(lba_mode), .host_data_out(data_out)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    logic [7:0]  m_status, m_error, m_feat, m_code;
    logic        m_pend, m_off, m_cmdv, m_lin, m_sec;
    logic [3:0]  m_head;
    logic [15:0] m_data;
    logic [7:0]  m_cur[2:5];
    logic [7:0]  m_prev[2:5];

    task automatic m_reset();
        m_status = 8'h40; m_error = 0; m_feat = 0; m_code = 0;
        m_pend = 0; m_off = 0; m_cmdv = 0; m_lin = 0; m_sec = 0;
        m_head = 0; m_data = 0;
        for (int i = 2; i <= 5; i++) begin m_cur[i] = 0; m_prev[i] = 0; end
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_read();
        logic [15:0] v = 16'h0;
        if (rd && cs_cmd) begin
            case (addr)
                3'd0: v = m_data;
                3'd1: v = {8'h0, m_error};
                3'd6: v = {8'h0, 1'b1, m_lin, 1'b1, m_sec, m_head};
                3'd7: v = {8'h0, m_status};
                default: v = {8'h0, m_cur[addr]};
            endcase
        end else if (rd && cs_ctl && addr == 3'd2) begin
            v = {8'h0, m_status};
        end
        return v;
    endfunction

    function automatic string rd_tag();
        if (cs_ctl) return "R8 alternate read";
        case (addr)
            3'd0: return "R10 data read";
            3'd1: return "R9 error read";
            3'd6: return "R3 select read";
            3'd7: return "R8 status read";
            default: return "R2 parameter read";
        endcase
    endfunction

    task automatic compare();
        chk(rd_tag(), rdata, m_read());
        chk("R7 intrq", intrq, m_pend & ~m_off);
        chk("R4 cmd_valid", cmd_valid, m_cmdv);
        if (m_cmdv) chk("R4 cmd_code", cmd_code, m_code);
        chk("R2 count_out", count_out, {m_prev[2], m_cur[2]});
        chk("R2 lba_out", lba_out, {m_prev[5], m_prev[4], m_prev[3], m_cur[5], m_cur[4], m_cur[3]});
        chk("R3 select outputs", {lba_mode, slave_sel, head_out}, {m_lin, m_sec, m_head});
        chk("R9 feat_out", feat_out, m_feat);
        chk("R10 data latch", data_out, m_data);
    endtask

    task automatic m_next();
        bit busy = m_status[7];
        bit take = cs_cmd && wr && addr == 3'd7 && !busy;
        bit fin  = done && busy;
        m_cmdv = 0;
        if (take) begin
            m_status = (m_status | 8'h80) & 8'hF6;
            m_cmdv = 1; m_code = wdata[7:0]; m_pend = 0;
        end else if (fin) begin
            m_status = dstat & 8'h6D; m_error = derr; m_pend = 1;
        end else if (cs_cmd && rd && addr == 3'd7) begin
            m_pend = 0;
        end
        if (cs_cmd && wr) begin
            case (addr)
                3'd0: m_data = wdata;
                3'd1: m_feat = wdata[7:0];
                3'd6: begin m_lin = wdata[6]; m_sec = wdata[4]; m_head = wdata[3:0]; end
                3'd7: ;
                default: begin m_prev[addr] = m_cur[addr]; m_cur[addr] = wdata[7:0]; end
            endcase
        end
        if (cs_ctl && wr && !cs_cmd && addr == 3'd2) m_off = wdata[1];
        if (dld) m_data = ddata;
    endtask

    task automatic tick();
        #3;
        compare();
        m_next();
        @(negedge clk);
        cs_cmd = 0; cs_ctl = 0; wr = 0; rd = 0; addr = 0; wdata = 0;
        done = 0; dld = 0; dstat = 0; derr = 0; ddata = 0;
    endtask

    task automatic wr_cmd(input logic [2:0] a, input logic [15:0] d);
        cs_cmd = 1; wr = 1; addr = a; wdata = d; tick();
    endtask
    task automatic rd_cmd(input logic [2:0] a);
        cs_cmd = 1; rd = 1; addr = a; tick();
    endtask
    task automatic wr_ctl(input logic [2:0] a, input logic [15:0] d);
        cs_ctl = 1; wr = 1; addr = a; wdata = d; tick();
    endtask
    task automatic rd_ctl(input logic [2:0] a);
        cs_ctl = 1; rd = 1; addr = a; tick();
    endtask
    task automatic finish_cmd(input logic [7:0] s, input logic [7:0] e);
        done = 1; dstat = s; derr = e; tick();
    endtask
    task automatic idle();
        tick();
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values seen at the ports
        #3;
        chk("R1 intrq", intrq, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 count", count_out, 0);
        chk("R1 lba", lba_out, 0);
        @(negedge clk);
        cs_cmd = 1; rd = 1; addr = 7; #3; chk("R1 status", rdata, 16'h0040); @(negedge clk);
        addr = 1; #3; chk("R1 error", rdata, 16'h0000); @(negedge clk);
        addr = 6; #3; chk("R1 select", rdata, 16'h00A0); @(negedge clk);
        cs_cmd = 0; rd = 0; addr = 0;

        // R2: two-deep parameter bytes, high byte first
        wr_cmd(2, 16'h0001); wr_cmd(2, 16'h0020);
        wr_cmd(3, 16'h0044); wr_cmd(3, 16'h0011);
        wr_cmd(4, 16'h0055); wr_cmd(4, 16'h0022);
        wr_cmd(5, 16'h0066); wr_cmd(5, 16'h0033);
        #3; chk("R2 count pair", count_out, 16'h0120);
        chk("R2 address bytes", lba_out, 48'h665544332211);
        @(negedge clk);
        rd_cmd(2); rd_cmd(3); rd_cmd(5);
        wr_cmd(3, 16'h0099); rd_cmd(3);

        // R3: device select
        wr_cmd(6, 16'h004B); rd_cmd(6);
        wr_cmd(6, 16'h0010); rd_cmd(6);

        // R9: features vs error
        wr_cmd(1, 16'h005A); rd_cmd(1);

        // R10: data latch, device wins on collision
        wr_cmd(0, 16'hBEEF); rd_cmd(0);
        dld = 1; ddata = 16'h1234; tick(); rd_cmd(0);
        cs_cmd = 1; wr = 1; addr = 0; wdata = 16'hAAAA; dld = 1; ddata = 16'h5555; tick();
        rd_cmd(0);

        // R6: completion while idle is ignored
        finish_cmd(8'hFF, 8'hFF); rd_cmd(7); rd_cmd(1);

        // R4/R5/R6/R8: command cycle with interrupt enabled
        wr_cmd(7, 16'h0024); rd_cmd(7);
        wr_cmd(7, 16'h0025); idle(); rd_ctl(2);
        finish_cmd(8'h59, 8'h04);
        rd_ctl(2); rd_ctl(2); rd_ctl(0);
        #3; chk("R8 intrq kept after alternate read", intrq, 1); @(negedge clk);
        rd_cmd(1); rd_cmd(7);
        #3; chk("R8 intrq cleared by status read", intrq, 0); @(negedge clk);

        // R7: masked interrupt survives, shows on unmask
        wr_ctl(2, 16'h0002);
        wr_cmd(7, 16'h00EC); idle(); finish_cmd(8'h48, 8'h00);
        idle(); idle();
        wr_ctl(2, 16'h0000); idle();
        // R4: a new command drops the pending interrupt
        wr_cmd(7, 16'h00A1); idle();
        finish_cmd(8'h41, 8'h10); rd_cmd(7); rd_ctl(2);

        // random single accesses
        for (int n = 0; n < 600; n++) begin
            int k = $urandom_range(0, 9);
            case (k)
                0, 1: wr_cmd(3'($urandom_range(0, 7)), 16'($urandom));
                2, 3: rd_cmd(3'($urandom_range(0, 7)));
                4: wr_ctl(3'($urandom_range(0, 7)), 16'($urandom));
                5: rd_ctl(3'($urandom_range(0, 7)));
                6: finish_cmd(8'($urandom), 8'($urandom));
                7: begin dld = 1; ddata = 16'($urandom); tick(); end
                8: wr_cmd(7, 16'($urandom));
                default: idle();
            endcase
        end

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule